// File: doc/BRIEF.md
# Masked Lane Element Writer

This block is the last stage of a vector unpack path. Each cycle it takes one 32-bit element, tagged with the lane it belongs to (X, Y, Z or W), and decides what 32-bit value goes into that lane of the destination vector. That value can be the element itself, the element plus a stored per-lane offset, or a running sum. It can also be a stored row or column constant. A per-lane, per-cycle write mask can instead suppress the write entirely.

Four row registers (one per lane) and four column registers (one per cycle slot) are held inside the block. They reset to zero and are loaded through a plain register-write port. The row registers also change as a side effect of the accumulating addition mode. Results leave one cycle after the element enters, with a valid flag and a separate write strobe.

Top module: `mask_lane_writer`

## Requirements
- R1: After reset `outValid` and `outWrite` are low, `outData` is zero, and every row and column register reads as zero.
- R2: The mask is consulted only when bit 28 of `cmdWord` is 1. When that bit is 0, the 2-bit selector is taken as 0, whatever `maskWord` holds.
- R3: For lane L (X=0, Y=1, Z=2, W=3) and cycle slot c, the selector is `maskWord[8*c+2*L +: 2]`. Any `inCycle` value of 3 or more uses c = 3.
- R4: Selector 1 produces the row register of the element's lane.
- R5: Selector 2 produces column register c, with c clamped to 3 as in R3.
- R6: Selector 3 protects the destination. `outValid` is high, `outWrite` is low, `outData` keeps its previous value, and no row register changes.
- R7: With selector 0 and `addMode` = 1 (offset), the result is `inData` plus the lane's row register. The row register is left unchanged.
- R8: With selector 0 and `addMode` = 2 (accumulate), the lane's row register becomes row + `inData`, and that new sum is the result.
- R9: With selector 0 and `addMode` of 0 or 3, the result is `inData` unchanged.
- R10: If `(cmdWord[7:0] & 8'h6F) == 8'h6F`, selector 0 passes `inData` through and ignores `addMode`. No row register changes.
- R11: When `regWrEn` is high, `regWrData` is written at the clock edge. The target is row register `regWrIdx` when `regWrCol` = 0, or column register `regWrIdx` when `regWrCol` = 1. A row write wins over an accumulate update to the same row in the same cycle.
- R12: Latency is one cycle. `outValid` equals the previous cycle's `inValid`, and `outLane` echoes the lane. The registers change only for valid elements, and `outData` changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Element present this cycle |
| inLane | input | 2 | Lane of the element: X=0, Y=1, Z=2, W=3 |
| inCycle | input | 3 | Cycle slot count (clamped to 3) |
| inData | input | 32 | Unpacked element value |
| cmdWord | input | 32 | Current command code (bit 28 enables masking, low byte used for bypass) |
| maskWord | input | 32 | Packed 2-bit write selectors |
| addMode | input | 2 | 0/3 pass, 1 offset, 2 accumulate |
| regWrEn | input | 1 | Register write strobe |
| regWrCol | input | 1 | 0 selects a row register, 1 a column register |
| regWrIdx | input | 2 | Register index |
| regWrData | input | 32 | Register write value |
| outValid | output | 1 | Result slot present |
| outWrite | output | 1 | Destination should be written |
| outLane | output | 2 | Lane of the result |
| outData | output | 32 | Value for the destination lane |

## Verification
The assertions take the control strobes as meaningful only in cycles where `inValid` is high. The accumulate check also assumes that no register-port write targets the same row in that cycle, so the property excludes that case explicitly and leaves it to a separate priority check. All inputs are driven on the falling clock edge. The random part of the stimulus deliberately produces same-row write collisions, masking on and off, bypass command codes and cycle counts above 3. Directed cases then pin each selector and mode to known register contents.

// File: rtl/mlw_pkg.sv
package mlw_pkg;
  typedef struct packed {
    logic       fire;    // valid element this cycle
    logic       useRow;  // selector 1
    logic       useCol;  // selector 2
    logic       keep;    // selector 3, write protected
    logic       addRow;  // offset mode
    logic       accum;   // accumulate mode
    logic [1:0] lane;
    logic [1:0] colIdx;  // clamped cycle slot
  } strobeT;
endpackage

// File: rtl/mlw_ctrl.sv
module mlw_ctrl
  import mlw_pkg::*;
#(
  parameter int CYC_W       = 3,
  parameter int CMD_W       = 32,
  parameter int MASK_W      = 32,
  parameter int MASK_EN_BIT = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inLane,
  input  logic [CYC_W-1:0]  inCycle,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [MASK_W-1:0] maskWord,
  input  logic [1:0]        addMode,
  output strobeT            strobe
);
  localparam int POS_W = $clog2(MASK_W);
  localparam logic [7:0] BYPASS_PAT = 8'h6F;

  logic [1:0]       cycClamp;
  logic [POS_W-1:0] bitPos;
  logic [1:0]       sel;
  logic             bypass;

  always_comb begin
    cycClamp = (inCycle > CYC_W'(3)) ? 2'd3 : inCycle[1:0];
    bitPos   = POS_W'({cycClamp, inLane, 1'b0});  // 8*c + 2*L
    sel      = cmdWord[MASK_EN_BIT] ? 2'(maskWord >> bitPos) : 2'd0;
    bypass   = (cmdWord[7:0] & BYPASS_PAT) == BYPASS_PAT;

    strobe.fire   = inValid;
    strobe.useRow = (sel == 2'd1);
    strobe.useCol = (sel == 2'd2);
    strobe.keep   = (sel == 2'd3);
    strobe.addRow = (sel == 2'd0) && !bypass && (addMode == 2'd1);
    strobe.accum  = (sel == 2'd0) && !bypass && (addMode == 2'd2);
    strobe.lane   = inLane;
    strobe.colIdx = cycClamp;
  end

  // R2: masking off leaves only the selector-0 path
  a_r2_mask_off: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cmdWord[MASK_EN_BIT]) |-> !(strobe.useRow || strobe.useCol || strobe.keep));

  // R10: bypass code never selects an addition mode
  a_r10_bypass_no_add: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdWord[7:0] & BYPASS_PAT) == BYPASS_PAT) |-> !(strobe.addRow || strobe.accum));

  // R3: column slot never exceeds 3 and matches small counts
  a_r3_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (inCycle < CYC_W'(3)) |-> (strobe.colIdx == inCycle[1:0]));
endmodule

// File: rtl/mlw_datapath.sv
module mlw_datapath
  import mlw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              regWrEn,
  input  logic              regWrCol,
  input  logic [1:0]        regWrIdx,
  input  logic [DATA_W-1:0] regWrData,
  output logic              outValid,
  output logic              outWrite,
  output logic [1:0]        outLane,
  output logic [DATA_W-1:0] outData
);
  logic [LANES-1:0][DATA_W-1:0] rowQ;
  logic [LANES-1:0][DATA_W-1:0] colQ;
  logic [DATA_W-1:0] rowSel, colSel, sum, result;

  always_comb begin
    rowSel = rowQ[strobe.lane];
    colSel = colQ[strobe.colIdx];
    sum    = inData + rowSel;
    if (strobe.useRow)                     result = rowSel;
    else if (strobe.useCol)                result = colSel;
    else if (strobe.addRow || strobe.accum) result = sum;
    else                                   result = inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (regWrEn && !regWrCol && regWrIdx == 2'(i))
          rowQ[i] <= regWrData;
        else if (strobe.fire && strobe.accum && strobe.lane == 2'(i))
          rowQ[i] <= sum;
        if (regWrEn && regWrCol && regWrIdx == 2'(i))
          colQ[i] <= regWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWrite <= 1'b0;
      outLane  <= '0;
      outData  <= '0;
    end else begin
      outValid <= strobe.fire;
      outWrite <= strobe.fire && !strobe.keep;
      if (strobe.fire) outLane <= strobe.lane;
      if (strobe.fire && !strobe.keep) outData <= result;
    end
  end

  // R12: one-cycle valid latency
  a_r12_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> outValid);
  a_r12_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> (!outValid && !outWrite && $stable(outData)));

  // R6: protected lane gives no strobe and keeps data
  a_r6_keep: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.keep) |=> (!outWrite && $stable(outData)));

  // R8: accumulated row equals emitted result
  a_r8_accum_row: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.accum && !(regWrEn && !regWrCol && regWrIdx == strobe.lane))
      |=> (outWrite && rowQ[$past(strobe.lane)] == outData));

  // R7: without accumulate or row write the rows stay put
  a_r7_rows_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.fire && strobe.accum) && !(regWrEn && !regWrCol) |=> $stable(rowQ));

  // R11: register-port row write wins
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrCol) |=> (rowQ[$past(regWrIdx)] == $past(regWrData)));
endmodule

// File: rtl/mask_lane_writer.sv
module mask_lane_writer
  import mlw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CYC_W  = 3,
  parameter int CMD_W  = 32,
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inLane,
  input  logic [CYC_W-1:0]  inCycle,
  input  logic [DATA_W-1:0] inData,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [MASK_W-1:0] maskWord,
  input  logic [1:0]        addMode,
  input  logic              regWrEn,
  input  logic              regWrCol,
  input  logic [1:0]        regWrIdx,
  input  logic [DATA_W-1:0] regWrData,
  output logic              outValid,
  output logic              outWrite,
  output logic [1:0]        outLane,
  output logic [DATA_W-1:0] outData
);
  localparam int LANES = 4;
  strobeT strobe;

  mlw_ctrl #(.CYC_W(CYC_W), .CMD_W(CMD_W), .MASK_W(MASK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLane(inLane),
    .inCycle(inCycle), .cmdWord(cmdWord), .maskWord(maskWord),
    .addMode(addMode), .strobe(strobe)
  );

  mlw_datapath #(.DATA_W(DATA_W), .LANES(LANES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .regWrEn(regWrEn), .regWrCol(regWrCol), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .outValid(outValid), .outWrite(outWrite),
    .outLane(outLane), .outData(outData)
  );
endmodule

// File: tb/mask_lane_writer_tb_top.sv
module mask_lane_writer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inLane = '0;
  logic [2:0] inCycle = '0;
  logic [31:0] inData = '0, cmdWord = '0, maskWord = '0, regWrData = '0;
  logic [1:0] addMode = '0, regWrIdx = '0;
  logic regWrEn = 1'b0, regWrCol = 1'b0;
  logic outValid, outWrite;
  logic [1:0] outLane;
  logic [31:0] outData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] rowM [4];
  logic [31:0] colM [4];
  logic [31:0] lastOut;

  localparam logic [31:0] MASK_ON = 32'h1000_0000;

  always #4 clk = ~clk;  // 125 MHz

  mask_lane_writer dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLane(inLane),
    .inCycle(inCycle), .inData(inData), .cmdWord(cmdWord),
    .maskWord(maskWord), .addMode(addMode), .regWrEn(regWrEn),
    .regWrCol(regWrCol), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .outValid(outValid), .outWrite(outWrite), .outLane(outLane),
    .outData(outData)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] selOf(logic [31:0] cmd, logic [31:0] mask,
                                       logic [1:0] lane, logic [2:0] cyc);
    int c = (cyc >= 3) ? 3 : int'(cyc);
    if (!cmd[28]) return 2'd0;
    return 2'((mask >> (8 * c + 2 * int'(lane))) & 32'h3);
  endfunction

  // Drive one cycle at the falling edge, predict, check at the next falling edge.
  task automatic step(string tag, bit v, logic [1:0] lane, logic [2:0] cyc,
                      logic [31:0] d, logic [31:0] cmd, logic [31:0] mask,
                      logic [1:0] mode, bit we = 0, bit wc = 0,
                      logic [1:0] wi = 0, logic [31:0] wd = 0);
    logic [1:0] s;
    bit byp, expW;
    logic [31:0] res;
    int c;
    inValid = v; inLane = lane; inCycle = cyc; inData = d; cmdWord = cmd;
    maskWord = mask; addMode = mode; regWrEn = we; regWrCol = wc;
    regWrIdx = wi; regWrData = wd;
    c = (cyc >= 3) ? 3 : int'(cyc);
    s = selOf(cmd, mask, lane, cyc);
    byp = ((cmd[7:0] & 8'h6F) == 8'h6F);
    res = d;
    case (s)
      2'd0: if (!byp && mode == 2'd1) res = d + rowM[lane];
            else if (!byp && mode == 2'd2) res = rowM[lane] + d;
      2'd1: res = rowM[lane];
      2'd2: res = colM[c];
      default: res = lastOut;
    endcase
    expW = v && (s != 2'd3);
    if (expW) lastOut = res;
    if (v && s == 2'd0 && !byp && mode == 2'd2) rowM[lane] = res;
    if (we) begin
      if (wc) colM[wi] = wd; else rowM[wi] = wd;
    end
    @(negedge clk);
    check({tag, " valid"}, 32'(outValid), 32'(v));
    if (v) begin
      check({tag, " write"}, 32'(outWrite), 32'(expW));
      check({tag, " lane"}, 32'(outLane), 32'(lane));
    end else begin
      check({tag, " write"}, 32'(outWrite), 32'd0);
    end
    check({tag, " data"}, outData, lastOut);
  endtask

  task automatic wrReg(string tag, bit col, logic [1:0] idx, logic [31:0] d);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1, col, idx, d);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin rowM[i] = '0; colM[i] = '0; end
    lastOut = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", 32'(outValid), 0);
    check("R1 reset write", 32'(outWrite), 0);
    check("R1 reset data", outData, 0);
    rstN = 1'b1;
    // R1: registers read zero after reset
    step("R1 row zero", 1, 2, 0, 32'hAAAA, MASK_ON, 32'h0000_0010, 0);
    step("R1 col zero", 1, 1, 1, 32'hBBBB, MASK_ON, 32'h0000_0800, 0);
    // R11: load rows and columns
    for (int i = 0; i < 4; i++) begin
      wrReg("R11 row load", 0, 2'(i), 32'h100 * (i + 1));
      wrReg("R11 col load", 1, 2'(i), 32'hC000_0000 + 32'(i));
    end
    // R4: selector 1 gives lane row, lane 2 at cycle 0 -> bits 5:4
    step("R4 row lane2", 1, 2, 0, 32'h5, MASK_ON, 32'h0000_0010, 0);
    // R5: selector 2 with cycle 5 clamps to column 3; lane 1 -> bits 27:26
    step("R5 col clamp", 1, 1, 5, 32'h5, MASK_ON, 32'h0800_0000, 0);
    step("R5 col slot1", 1, 0, 1, 32'h5, MASK_ON, 32'h0000_0200, 0);
    // R3: cycle 3 and 7 share slot 3; lane 3 cycle 1 -> bits 15:14
    step("R3 cyc3", 1, 3, 3, 32'h9, MASK_ON, 32'h4000_0000, 0);
    step("R3 cyc7", 1, 3, 7, 32'h9, MASK_ON, 32'h4000_0000, 0);
    step("R3 lane3 cyc1", 1, 3, 1, 32'h9, MASK_ON, 32'h0000_8000, 0);
    // R2: masking off, all-ones mask ignored
    step("R2 mask off", 1, 0, 0, 32'h1234, 32'h0, 32'hFFFF_FFFF, 0);
    // R6: write protect keeps data and row
    step("R6 keep", 1, 1, 2, 32'hDEAD, MASK_ON, 32'hFFFF_FFFF, 2);
    step("R6 row after keep", 1, 1, 0, 32'h0, MASK_ON, 32'h0000_0004, 0);
    // R7: offset then row readback unchanged
    step("R7 offset", 1, 0, 0, 32'h22, 32'h0, 0, 1);
    step("R7 row kept", 1, 0, 0, 32'h0, MASK_ON, 32'h1, 0);
    // R8: accumulate twice then read
    step("R8 accum a", 1, 3, 0, 32'h10, 32'h0, 0, 2);
    step("R8 accum b", 1, 3, 0, 32'h7, 32'h0, 0, 2);
    step("R8 row read", 1, 3, 0, 32'h0, MASK_ON, 32'h40, 0);
    // R9: modes 0 and 3 pass through
    step("R9 mode0", 1, 2, 0, 32'hF00D, 32'h0, 0, 0);
    step("R9 mode3", 1, 2, 0, 32'hBEEF, 32'h0, 0, 3);
    // R10: bypass code with accumulate mode
    step("R10 bypass", 1, 1, 0, 32'h77, 32'h0000_006F, 0, 2);
    step("R10 bypass ff", 1, 1, 0, 32'h78, 32'h0000_00FF, 0, 1);
    step("R10 row kept", 1, 1, 0, 32'h0, MASK_ON, 32'h4, 0);
    // R11: row write wins over accumulate on same row
    step("R11 priority", 1, 0, 0, 32'h5, 32'h0, 0, 2, 1, 0, 0, 32'h0BAD_0000);
    step("R11 row read", 1, 0, 0, 32'h0, MASK_ON, 32'h1, 0);
    // R12: idle cycle holds data
    step("R12 idle", 0, 3, 0, 32'h9999, 32'h0, 0, 2);
    // Random mix
    void'($urandom(32'd4242));
    for (int n = 0; n < 600; n++) begin
      logic [31:0] cmd = $urandom;
      if (($urandom % 5) == 0) cmd[7:0] = 8'h6F | 8'($urandom & 32'h90);
      step("R12 random", ($urandom % 4) != 0, 2'($urandom), 3'($urandom),
           $urandom, cmd, $urandom, 2'($urandom), ($urandom % 3) == 0,
           1'($urandom), 2'($urandom), $urandom);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule